// File: doc/BRIEF.md
# DMA Transfer Unit Bus Cycle Sequencer

This block drives the bus accesses of one DMA transfer unit: a read phase on the source side followed by a write phase on the destination side. A unit is either one byte or one 16-bit word. A word is carried as a single access when the bus is 16 bits wide and both addresses are even. Otherwise it becomes two byte accesses per side, with the lower address first.

Each access holds its strobe for a number of cycles. That number is a coefficient chosen by the memory region, the bus type and the wait-state setting of that side. An external 8-bit bus is only allowed when external memory is enabled. Asking for it in single-chip operation ends the unit at once with an error flag and drives no strobes. Multi-unit address stepping, request handling and arbitration are left to the surrounding controller.

Top module: `dma_xfer_seq`

## Requirements
- R1: After an accepted start, the number of cycles with `rd_o` high is n×j and the number with `wr_o` high is n×k. Here n is the access count per side and j, k are the read and write coefficients. `done_o` is high in the cycle right after the last write cycle.
- R2: A byte unit (`word_i`=0) uses exactly one read access and one write access, whatever the address parity and bus width.
- R3: A word unit (`word_i`=1) on a wide bus (`narrow_bus_i`=0) with both addresses even uses one read access and one write access.
- R4: A word unit whose source or destination address is odd, or that runs on a narrow bus (`narrow_bus_i`=1), is split into two read accesses and two write accesses.
- R5: `addr_o` shows the source address during reads and the destination address during writes. In a split unit the first access uses the base address and the second uses base+1, modulo 2^AW.
- R6: Region code 0 (internal memory) has coefficient 1 at wait 0 and 2 at any nonzero wait. Region code 1 (register area) has coefficient 2 at any wait setting. The same values apply to reads and writes.
- R7: Region code 2 (external multiplexed bus) has coefficient w+1 for wait w of 1, 2 or 3. A wait of 0 is treated as 1, which gives coefficient 2. Reads and writes are the same.
- R8: Region code 3 (external separate bus) at wait 0 has read coefficient 1 and write coefficient 2. At wait w of 1 to 3, both coefficients are w+1.
- R9: Every read cycle of a unit comes before its first write cycle. `busy_o` is high in every strobe cycle and low in the done cycle. Out of reset all outputs are low.
- R10: `start_i` is ignored while `busy_o` is high. The unit in progress keeps its counts, addresses and timing.
- R11: A start with `narrow_bus_i`=1 and `ext_mode_i`=0 makes `done_o` and `err_o` high together in the next cycle, with no read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one transfer unit |
| src_addr_i | input | AW | Source byte address |
| dst_addr_i | input | AW | Destination byte address |
| word_i | input | 1 | 1: 16-bit unit, 0: 8-bit unit |
| narrow_bus_i | input | 1 | 1: external bus is 8 bits wide |
| ext_mode_i | input | 1 | 1: external memory enabled, 0: single-chip |
| rd_region_i | input | 2 | Source region code (0 int mem, 1 regs, 2 ext mux, 3 ext separate) |
| rd_wait_i | input | 2 | Source wait states |
| wr_region_i | input | 2 | Destination region code |
| wr_wait_i | input | 2 | Destination wait states |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | AW | Byte address of the current access |
| busy_o | output | 1 | Unit in progress |
| done_o | output | 1 | One-cycle end-of-unit pulse |
| err_o | output | 1 | Illegal width/mode, valid with done_o |

## Verification
The bench builds the block with the default 16-bit address width. At that width, a base address of 0xFFFF makes the second byte of a split word wrap to 0x0000, and every region, wait and width combination is reachable with random draws. Directed cases cover each split trigger, the uneven read and write costs of the separate bus at wait 0, the rejected single-chip narrow combination, and a start pulse arriving in the middle of a unit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    RGN_INT_MEM = 2'd0,
    RGN_REGS    = 2'd1,
    RGN_EXT_MUX = 2'd2,
    RGN_EXT_SEP = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RD, ST_WR, ST_FIN
  } state_e;

  localparam int CW = 3;  // coefficient width, max value 4
endpackage

// File: rtl/dma_coef.sv
module dma_coef
  import dma_seq_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0
) (
  input  logic [1:0]    region_i,
  input  logic [1:0]    wait_i,
  output logic [CW-1:0] coef_o
);
  logic [CW-1:0] w_plus1;
  assign w_plus1 = {1'b0, wait_i} + 3'd1;

  always_comb begin
    unique case (region_e'(region_i))
      RGN_INT_MEM: coef_o = (wait_i == 2'd0) ? 3'd1 : 3'd2;
      RGN_REGS:    coef_o = 3'd2;
      RGN_EXT_MUX: coef_o = (wait_i == 2'd0) ? 3'd2 : w_plus1;
      RGN_EXT_SEP: coef_o = (wait_i == 2'd0) ? (IS_WRITE ? 3'd2 : 3'd1) : w_plus1;
      default:     coef_o = 3'd2;
    endcase
  end
endmodule

// File: rtl/dma_unit_plan.sv
module dma_unit_plan (
  input  logic word_i,
  input  logic narrow_bus_i,
  input  logic ext_mode_i,
  input  logic src_lsb_i,
  input  logic dst_lsb_i,
  output logic split_o,
  output logic illegal_o
);
  assign illegal_o = narrow_bus_i & ~ext_mode_i;
  assign split_o   = word_i & (narrow_bus_i | src_lsb_i | dst_lsb_i);
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          illegal_i,
  input  logic          split_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] j_i,
  input  logic [CW-1:0] k_i,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  state_e        state_q;
  logic [CW-1:0] cnt_q, j_q, k_q;
  logic          idx_q, split_q, err_q;
  logic [AW-1:0] src_q, dst_q;
  logic          accept, last_cyc;

  assign accept   = start_i && (state_q == ST_IDLE || state_q == ST_FIN);
  assign last_cyc = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      j_q     <= '0;
      k_q     <= '0;
      idx_q   <= 1'b0;
      split_q <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RD: begin
          if (!last_cyc) cnt_q <= cnt_q - 3'd1;
          else if (split_q && !idx_q) begin
            idx_q <= 1'b1;
            cnt_q <= j_q - 3'd1;
          end else begin
            state_q <= ST_WR;
            idx_q   <= 1'b0;
            cnt_q   <= k_q - 3'd1;
          end
        end
        ST_WR: begin
          if (!last_cyc) cnt_q <= cnt_q - 3'd1;
          else if (split_q && !idx_q) begin
            idx_q <= 1'b1;
            cnt_q <= k_q - 3'd1;
          end else begin
            state_q <= ST_FIN;
            idx_q   <= 1'b0;
          end
        end
        default: begin  // idle or done cycle
          if (accept) begin
            src_q   <= src_i;
            dst_q   <= dst_i;
            j_q     <= j_i;
            k_q     <= k_i;
            split_q <= split_i;
            idx_q   <= 1'b0;
            cnt_q   <= j_i - 3'd1;
            err_q   <= illegal_i;
            state_q <= illegal_i ? ST_FIN : ST_RD;
          end else begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
          end
        end
      endcase
    end
  end

  assign rd_o   = (state_q == ST_RD);
  assign wr_o   = (state_q == ST_WR);
  assign busy_o = rd_o | wr_o;
  assign done_o = (state_q == ST_FIN);
  assign err_o  = done_o & err_q;

  always_comb begin
    if (rd_o)      addr_o = src_q + AW'(idx_q);
    else if (wr_o) addr_o = dst_q + AW'(idx_q);
    else           addr_o = '0;
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          word_i,
  input  logic          narrow_bus_i,
  input  logic          ext_mode_i,
  input  logic [1:0]    rd_region_i,
  input  logic [1:0]    rd_wait_i,
  input  logic [1:0]    wr_region_i,
  input  logic [1:0]    wr_wait_i,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  logic [1:0]    side_rgn  [2];
  logic [1:0]    side_wait [2];
  logic [CW-1:0] side_coef [2];
  logic          split, illegal;

  assign side_rgn[0]  = rd_region_i;
  assign side_rgn[1]  = wr_region_i;
  assign side_wait[0] = rd_wait_i;
  assign side_wait[1] = wr_wait_i;

  for (genvar g = 0; g < 2; g++) begin : g_side
    dma_coef #(.IS_WRITE(g == 1)) u_coef (
      .region_i(side_rgn[g]),
      .wait_i  (side_wait[g]),
      .coef_o  (side_coef[g])
    );
  end

  dma_unit_plan u_plan (
    .word_i      (word_i),
    .narrow_bus_i(narrow_bus_i),
    .ext_mode_i  (ext_mode_i),
    .src_lsb_i   (src_addr_i[0]),
    .dst_lsb_i   (dst_addr_i[0]),
    .split_o     (split),
    .illegal_o   (illegal)
  );

  dma_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .illegal_i(illegal),
    .split_i  (split),
    .src_i    (src_addr_i),
    .dst_i    (dst_addr_i),
    .j_i      (side_coef[0]),
    .k_i      (side_coef[1]),
    .rd_o     (rd_o),
    .wr_o     (wr_o),
    .addr_o   (addr_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          narrow_bus_i,
  input logic          ext_mode_i,
  input logic          rd_o,
  input logic          wr_o,
  input logic [AW-1:0] addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o
);
  a_r9_no_read_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !rd_o);
  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !rd_o && !wr_o);
  a_r1_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && !done_o |=> wr_o || done_o);
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);
  a_r11_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !rd_o && !wr_o);
  a_r11_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && narrow_bus_i && !ext_mode_i |=> err_o && done_o);
  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && $past(rd_o) && addr_o != $past(addr_o) |-> addr_o == $past(addr_o) + AW'(1));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .narrow_bus_i(narrow_bus_i),
  .ext_mode_i  (ext_mode_i),
  .rd_o        (rd_o),
  .wr_o        (wr_o),
  .addr_o      (addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/dma_xfer_seq_test.sv
`timescale 1ns/1ps
module dma_xfer_seq_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic          word = 1'b0, narrow = 1'b0, ext = 1'b1;
  logic [1:0]    rrg = '0, rwt = '0, wrg = '0, wwt = '0;
  logic          rd, wr, busy, done, err;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_xfer_seq #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_i(src), .dst_addr_i(dst), .word_i(word),
    .narrow_bus_i(narrow), .ext_mode_i(ext),
    .rd_region_i(rrg), .rd_wait_i(rwt), .wr_region_i(wrg), .wr_wait_i(wwt),
    .rd_o(rd), .wr_o(wr), .addr_o(addr), .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic int exp_coef(logic [1:0] rg, logic [1:0] w, bit is_wr);
    int wi = int'(w);
    case (rg)
      2'd0:    return (wi == 0) ? 1 : 2;                   // R6
      2'd1:    return 2;                                   // R6
      2'd2:    return (wi == 0) ? 2 : wi + 1;              // R7
      default: return (wi == 0) ? (is_wr ? 2 : 1) : wi + 1; // R8
    endcase
  endfunction

  function automatic int exp_n(logic wd, logic nb, logic [AW-1:0] s, logic [AW-1:0] d);
    if (!wd) return 1;                   // R2
    if (nb || s[0] || d[0]) return 2;    // R4
    return 1;                            // R3
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  // one unit; poke = send an extra start mid-unit with altered inputs (R10)
  task automatic run(logic [AW-1:0] s, logic [AW-1:0] d, logic wd, logic nb, logic ex,
                     logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [1:0] e,
                     bit poke, string tag);
    int j, k, n, rdc, wrc, bad_addr, bad_order, guard;
    bit ill;
    @(negedge clk);
    src = s; dst = d; word = wd; narrow = nb; ext = ex;
    rrg = a; rwt = b; wrg = c; wwt = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    j = exp_coef(a, b, 1'b0);
    k = exp_coef(c, e, 1'b1);
    n = exp_n(wd, nb, s, d);
    ill = nb && !ex;
    rdc = 0; wrc = 0; bad_addr = 0; bad_order = 0; guard = 0;
    while (!done && guard < 64) begin
      if (!busy) bad_order++;
      if (rd) begin
        if (wrc > 0) bad_order++;
        if (addr != s + AW'(rdc / j)) bad_addr++;
        rdc++;
      end
      if (wr) begin
        if (addr != d + AW'(wrc / k)) bad_addr++;
        wrc++;
      end
      if (poke && guard == 1) begin
        start = 1'b1; src = ~s; dst = ~d; word = ~wd; rrg = ~a; wwt = ~e;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    if (ill) begin
      check(rdc == 0 && wrc == 0 && err && done, {"R11 ", tag}, rdc + wrc, 0);
    end else begin
      check(rdc == n * j, {"R1 reads ", tag}, rdc, n * j);
      check(wrc == n * k, {"R1 writes ", tag}, wrc, n * k);
      check(bad_addr == 0, {"R5 addr ", tag}, bad_addr, 0);
      check(bad_order == 0 && done && !err && !busy, {"R9 order ", tag}, bad_order, 0);
    end
    @(negedge clk);  // let done cycle pass
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!rd && !wr && !busy && !done && !err, "R9 reset", int'({rd, wr, busy, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 byte unit, odd narrow bus
    run(16'h1001, 16'h2003, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, "R2 byte");
    // R3 aligned word
    run(16'h1000, 16'h2000, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 2'd1, 2'd0, 1'b0, "R3 even");
    // R4 odd source, odd dest, narrow bus
    run(16'h1001, 16'h2000, 1'b1, 1'b0, 1'b1, 2'd2, 2'd3, 2'd2, 2'd1, 1'b0, "R4 odd src");
    run(16'h1000, 16'h2001, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, "R4 odd dst");
    run(16'h1000, 16'h2000, 1'b1, 1'b1, 1'b1, 2'd3, 2'd2, 2'd3, 2'd2, 1'b0, "R4 narrow");
    // R5 wrap of second byte
    run(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0, 2'd1, 1'b0, "R5 wrap");
    // R7 mux with wait 0, R8 separate wait 0
    run(16'h0010, 16'h0020, 1'b1, 1'b0, 1'b1, 2'd2, 2'd0, 2'd2, 2'd0, 1'b0, "R7 mux w0");
    run(16'h0010, 16'h0020, 1'b0, 1'b0, 1'b1, 2'd3, 2'd0, 2'd3, 2'd0, 1'b0, "R8 sep w0");
    run(16'h0011, 16'h0021, 1'b1, 1'b0, 1'b1, 2'd3, 2'd3, 2'd3, 2'd0, 1'b0, "R8 sep split");
    // R11 rejected combination, both unit sizes
    run(16'h0010, 16'h0020, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, "word");
    run(16'h0011, 16'h0020, 1'b0, 1'b1, 1'b0, 2'd3, 2'd3, 2'd3, 2'd3, 1'b0, "byte");
    // R10 start while busy
    run(16'h4000, 16'h5000, 1'b1, 1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 2'd2, 1'b1, "R10 poke");
    run(16'h4001, 16'h5002, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd3, 2'd0, 1'b1, "R10 poke byte");

    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] s, d;
      logic [5:0] r;
      s = AW'($urandom);
      d = AW'($urandom);
      r = 6'($urandom);
      run(s, d, 1'($urandom), 1'($urandom), (r[4:0] != 0), 2'($urandom), 2'($urandom),
          2'($urandom), 2'($urandom), r[5], "R6 random");
    end
    summary();
  end
endmodule